// File: doc/BRIEF.md
# Configuration Stream Checksum Verifier

At power-up, an upstream reader pulls configuration records out of a serial memory and hands them over one byte at a time. This block watches that byte stream. It adds every byte into an 8-bit running sum and recognises the two-byte done record that closes the stream. When that record arrives, it judges whether the stream is intact. It also sits on the register-write path that the stream drives: a write that targets an address outside the configured map is blocked and flagged.

If anything goes wrong, the block stops the load. A failed checksum, a malformed done record, or a stream that ends too early each cause a one-cycle abort pulse to the reader and a sticky halt request. The halt keeps the device out of normal operation, while the status flags stay readable for debug. The done flag rises on every kind of ending, good or bad. All flags hold until a synchronous clear or reset, and a clear also restarts the sum for a fresh load.

Top module: `cfg_stream_checker`

## Requirements
- R1: After reset, all status flags, the halt request and the abort pulse are low.
- R2: A byte accepted with the record-start strobe whose bits 1:0 equal 3 opens the done record, and the next accepted byte is its checksum byte. When the modulo-256 sum of every accepted byte since the last clear, both done-record bytes included, equals 0xFF, the block sets the done flag and raises no error, abort or halt.
- R3: If that final sum is not 0xFF and checksum checking is enabled, the block sets the checksum-error flag, the done flag and the halt request, and pulses abort.
- R4: While the ignore-checksum input is high at the checksum byte, a mismatching sum sets only the done flag, with no error, abort or halt.
- R5: A done-record first byte (bits 1:0 equal 3, record-start set) with any of bits 7:2 set is a format error. It sets the format-error flag, the done flag and the halt request, and pulses abort, without waiting for a checksum byte. Record-start bytes with other type codes are only summed.
- R6: An end-of-data strobe that arrives before the checksum byte has been accepted is a truncation error, with the same done, halt and abort behaviour. If it coincides with a valid byte, the strobe takes priority and the byte is not counted.
- R7: A write request whose address lies inside any configured inclusive base/limit range passes to the write-enable output in the same cycle. A request whose address lies outside all ranges is dropped, and the unmapped-write flag sets on the next edge, with no halt or abort.
- R8: While the halt request is high, no write request reaches the write-enable output.
- R9: The abort output is high for exactly one cycle per detected error.
- R10: The synchronous clear input drops every flag and the halt request, zeroes the sum and restarts record tracking.
- R11: Once a load has ended, further bytes and end-of-data strobes have no effect until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of status and restart of the load |
| byte_vld_i | input | 1 | A stream byte is present on byte_i |
| byte_i | input | 8 | Stream byte |
| sor_i | input | 1 | The present byte is the first byte of a record |
| eod_i | input | 1 | The reader has reached the end of its data |
| ign_csum_i | input | 1 | Suppress checksum mismatch errors |
| wr_req_i | input | 1 | Register write request from the stream decoder |
| wr_addr_i | input | AW | Target address of the write request |
| wr_en_o | output | 1 | Gated write enable to the register file |
| done_o | output | 1 | Load has ended (sticky) |
| csum_err_o | output | 1 | Checksum mismatch (sticky) |
| fmt_err_o | output | 1 | Malformed done record (sticky) |
| trunc_err_o | output | 1 | Stream ended before the done record completed (sticky) |
| unmapped_o | output | 1 | A write to an unmapped address was dropped (sticky) |
| halt_o | output | 1 | Halt request (sticky) |
| abort_o | output | 1 | One-cycle abort pulse to the reader |

## Verification
The assertions check the cycle-level rules on every cycle. The abort pulse never lasts two cycles, and it always comes with halt and done. Halt stays set until a clear. A dropped write under no halt always sets the unmapped flag. A checksum error never rises while the ignore input was high. Record tracking never leaves its final state without a clear. The bench scenarios cover the rest. Only they can show that a stream built with a correct complemented checksum passes while a corrupted one fails. They also show that bytes arriving after the end are ignored, that an early end is caught in each phase, and that the range decode separates mapped from unmapped addresses.

// File: rtl/cfg_chk_pkg.sv
package cfg_chk_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_TERM, ST_FIN} trk_st_e;

  localparam logic [1:0] TYPE_DONE = 2'd3;
  localparam logic [7:0] SUM_GOOD  = 8'hFF;

  typedef struct packed {
    logic ok;
    logic csum_bad;
    logic fmt_bad;
    logic trunc;
  } end_evt_t;
endpackage

// File: rtl/cfg_sum_acc.sv
module cfg_sum_acc #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         add_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] sum_nxt_o
);
  logic [W-1:0] sum_q;

  assign sum_nxt_o = sum_q + byte_i;
  assign sum_o     = sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (add_i)  sum_q <= sum_nxt_o;
  end
endmodule

// File: rtl/cfg_term_fsm.sv
module cfg_term_fsm
  import cfg_chk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       vld_i,
  input  logic       sor_i,
  input  logic       eod_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] sum_nxt_i,
  output logic       acc_o,
  output end_evt_t   evt_o
);
  trk_st_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    acc_o = 1'b0;
    evt_o = '0;
    unique case (st_q)
      ST_RUN: begin
        if (eod_i) begin
          evt_o.trunc = 1'b1;
          st_d        = ST_FIN;
        end else if (vld_i) begin
          acc_o = 1'b1;
          if (sor_i && byte_i[1:0] == TYPE_DONE) begin
            if (byte_i[7:2] != '0) begin
              evt_o.fmt_bad = 1'b1;
              st_d          = ST_FIN;
            end else begin
              st_d = ST_TERM;
            end
          end
        end
      end
      ST_TERM: begin
        if (eod_i) begin
          evt_o.trunc = 1'b1;
          st_d        = ST_FIN;
        end else if (vld_i) begin
          acc_o = 1'b1;
          if (sum_nxt_i == SUM_GOOD) evt_o.ok       = 1'b1;
          else                       evt_o.csum_bad = 1'b1;
          st_d = ST_FIN;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= ST_RUN;
    else if (clr_i) st_q <= ST_RUN;
    else            st_q <= st_d;
  end

  // R11
  fin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIN && !clr_i) |=> st_q == ST_FIN);

  // R2
  one_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_o));
endmodule

// File: rtl/cfg_addr_map.sv
module cfg_addr_map #(
  parameter int unsigned AW     = 12,
  parameter int unsigned NR     = 3,
  parameter logic [NR*AW-1:0] LO = '0,
  parameter logic [NR*AW-1:0] HI = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic [NR-1:0] hit_v;

  for (genvar g = 0; g < NR; g++) begin : g_rng
    assign hit_v[g] = (addr_i >= LO[g*AW +: AW]) && (addr_i <= HI[g*AW +: AW]);
  end

  assign hit_o = |hit_v;
endmodule

// File: rtl/cfg_stream_checker.sv
module cfg_stream_checker
  import cfg_chk_pkg::*;
#(
  parameter int unsigned AW     = 12,
  parameter int unsigned NR     = 3,
  parameter logic [NR*AW-1:0] RNG_LO = {12'h800, 12'h400, 12'h000},
  parameter logic [NR*AW-1:0] RNG_HI = {12'h803, 12'h47F, 12'h0FF}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic          sor_i,
  input  logic          eod_i,
  input  logic          ign_csum_i,
  input  logic          wr_req_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic          wr_en_o,
  output logic          done_o,
  output logic          csum_err_o,
  output logic          fmt_err_o,
  output logic          trunc_err_o,
  output logic          unmapped_o,
  output logic          halt_o,
  output logic          abort_o
);
  logic       acc;
  logic [7:0] sum, sum_nxt;
  logic       hit;
  end_evt_t   evt;
  logic       csum_fail, err, ending;

  cfg_sum_acc #(.W(8)) u_sum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .add_i     (acc),
    .byte_i    (byte_i),
    .sum_o     (sum),
    .sum_nxt_o (sum_nxt)
  );

  cfg_term_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .vld_i     (byte_vld_i),
    .sor_i     (sor_i),
    .eod_i     (eod_i),
    .byte_i    (byte_i),
    .sum_nxt_i (sum_nxt),
    .acc_o     (acc),
    .evt_o     (evt)
  );

  cfg_addr_map #(.AW(AW), .NR(NR), .LO(RNG_LO), .HI(RNG_HI)) u_map (
    .addr_i (wr_addr_i),
    .hit_o  (hit)
  );

  assign csum_fail = evt.csum_bad & ~ign_csum_i;
  assign err       = csum_fail | evt.fmt_bad | evt.trunc;
  assign ending    = |evt;
  assign wr_en_o   = wr_req_i & hit & ~halt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      csum_err_o  <= 1'b0;
      fmt_err_o   <= 1'b0;
      trunc_err_o <= 1'b0;
      unmapped_o  <= 1'b0;
      halt_o      <= 1'b0;
      abort_o     <= 1'b0;
    end else if (clr_i) begin
      done_o      <= 1'b0;
      csum_err_o  <= 1'b0;
      fmt_err_o   <= 1'b0;
      trunc_err_o <= 1'b0;
      unmapped_o  <= 1'b0;
      halt_o      <= 1'b0;
      abort_o     <= 1'b0;
    end else begin
      done_o      <= done_o | ending;
      csum_err_o  <= csum_err_o | csum_fail;
      fmt_err_o   <= fmt_err_o | evt.fmt_bad;
      trunc_err_o <= trunc_err_o | evt.trunc;
      unmapped_o  <= unmapped_o | (wr_req_i & ~hit);
      halt_o      <= halt_o | err;
      abort_o     <= err;
    end
  end

  // R9
  abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  // R3
  abort_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (halt_o && done_o));

  // R3
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !clr_i) |=> halt_o);

  // R4
  ign_csum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csum_err_o) |-> $past(!ign_csum_i));

  // R7
  unmapped_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && !wr_en_o && !halt_o && !clr_i) |=> unmapped_o);

  // R10
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!done_o && !halt_o && !abort_o));

  // R1
  always_comb begin
    if (!rst_ni) reset_state_chk: assert (!done_o && !halt_o && !abort_o);
  end
endmodule

// File: tb/cfg_stream_checker_tb.sv
module cfg_stream_checker_tb;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clr_i = 1'b0;
  logic          byte_vld_i = 1'b0;
  logic [7:0]    byte_i = '0;
  logic          sor_i = 1'b0;
  logic          eod_i = 1'b0;
  logic          ign_csum_i = 1'b0;
  logic          wr_req_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic wr_en_o, done_o, csum_err_o, fmt_err_o, trunc_err_o, unmapped_o, halt_o, abort_o;

  int nchk = 0;
  int nerr = 0;

  typedef struct {
    string req;
    bit csum; bit fmt; bit trunc; bit halt;
  } exp_t;
  exp_t q[$];
  exp_t e;
  bit   done_q = 1'b0;

  always #5 clk = ~clk;

  cfg_stream_checker u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .sor_i(sor_i), .eod_i(eod_i), .ign_csum_i(ign_csum_i),
    .wr_req_i(wr_req_i), .wr_addr_i(wr_addr_i), .wr_en_o(wr_en_o),
    .done_o(done_o), .csum_err_o(csum_err_o), .fmt_err_o(fmt_err_o),
    .trunc_err_o(trunc_err_o), .unmapped_o(unmapped_o), .halt_o(halt_o),
    .abort_o(abort_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compare each ending against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && done_o && !done_q) begin
      if (q.size() == 0) chk("R11 unexpected done", 1, 0);
      else begin
        e = q.pop_front();
        chk({e.req, " csum_err"}, csum_err_o, e.csum);
        chk({e.req, " fmt_err"}, fmt_err_o, e.fmt);
        chk({e.req, " trunc_err"}, trunc_err_o, e.trunc);
        chk({e.req, " halt"}, halt_o, e.halt);
        chk({e.req, " abort"}, abort_o, e.halt);
      end
    end
    done_q = done_o;
  end

  // generator helper: complement of the sum with the checksum byte as zero
  function automatic logic [7:0] gen_csum(input logic [7:0] body_sum);
    logic [7:0] s;
    s = body_sum + 8'h03;
    return ~s;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit s);
    byte_vld_i = 1'b1; byte_i = b; sor_i = s;
    @(negedge clk);
    byte_vld_i = 1'b0; sor_i = 1'b0;
  endtask

  task automatic send_body(input int n, input int seed, output logic [7:0] sum);
    sum = '0;
    for (int i = 0; i < n; i++) begin
      int v;
      logic [7:0] b;
      v = seed * 37 + i * 91 + 200;
      b = v[7:0];
      if (i % 4 == 0) b[1:0] = 2'(i % 3);
      sum = sum + b;
      send_byte(b, (i % 4) == 0);
    end
  endtask

  task automatic send_stream(input int n, input int seed, input logic [7:0] corrupt);
    logic [7:0] s;
    send_body(n, seed, s);
    send_byte(8'h03, 1'b1);
    send_byte(gen_csum(s) ^ corrupt, 1'b0);
  endtask

  task automatic push(input string r, input bit c, input bit f, input bit t, input bit h);
    exp_t x;
    x.req = r; x.csum = c; x.fmt = f; x.trunc = t; x.halt = h;
    q.push_back(x);
  endtask

  task automatic do_clr();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  task automatic wr_try(input logic [AW-1:0] a, input bit exp_en, input string r);
    wr_req_i = 1'b1; wr_addr_i = a;
    #1;
    chk(r, wr_en_o, exp_en);
    @(negedge clk);
    wr_req_i = 1'b0;
  endtask

  initial begin
    logic [7:0] s;
    #1;
    // R1 reset state
    chk("R1 done", done_o, 0);
    chk("R1 halt", halt_o, 0);
    chk("R1 abort", abort_o, 0);
    chk("R1 unmapped", unmapped_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R7 mapped / unmapped writes, range edges
    wr_try(12'h0FF, 1, "R7 mapped limit");
    wr_try(12'h400, 1, "R7 mapped base");
    chk("R7 no flag on mapped", unmapped_o, 0);
    wr_try(12'h480, 0, "R7 unmapped drop");
    chk("R7 unmapped flag", unmapped_o, 1);
    chk("R7 no halt", halt_o, 0);
    chk("R7 no abort", abort_o, 0);

    // R10 clear drops unmapped flag
    do_clr();
    chk("R10 unmapped cleared", unmapped_o, 0);

    // R2 good stream with sum wrap
    push("R2 good", 0, 0, 0, 0);
    send_stream(13, 5, 8'h00);
    chk("R2 done", done_o, 1);
    @(negedge clk);
    chk("R2 no abort later", abort_o, 0);

    // R11 bytes and eod after the end are ignored
    send_byte(8'h07, 1'b1);
    send_byte(8'h00, 1'b0);
    eod_i = 1'b1; @(negedge clk); eod_i = 1'b0;
    chk("R11 fmt after end", fmt_err_o, 0);
    chk("R11 trunc after end", trunc_err_o, 0);
    chk("R11 halt after end", halt_o, 0);

    // R3/R9 checksum mismatch
    do_clr();
    push("R3 mismatch", 1, 0, 0, 1);
    send_stream(9, 11, 8'h10);
    @(negedge clk);
    chk("R9 abort one cycle", abort_o, 0);
    chk("R3 halt sticky", halt_o, 1);
    // R8 writes blocked while halted
    wr_try(12'h010, 0, "R8 halted write");

    // R10 clear restores
    do_clr();
    chk("R10 done cleared", done_o, 0);
    chk("R10 halt cleared", halt_o, 0);
    chk("R10 csum cleared", csum_err_o, 0);
    wr_try(12'h801, 1, "R10 write after clear");

    // R4 mismatch ignored
    ign_csum_i = 1'b1;
    push("R4 ignored", 0, 0, 0, 0);
    send_stream(6, 3, 8'h01);
    ign_csum_i = 1'b0;
    chk("R4 done", done_o, 1);

    // R5 format error on reserved bits
    do_clr();
    push("R5 fmt", 0, 1, 0, 1);
    send_body(5, 7, s);
    send_byte(8'h0B, 1'b1);
    send_byte(gen_csum(s), 1'b0);
    chk("R5 no csum err", csum_err_o, 0);

    // R5 type 3 without record start is only data; R2 still passes
    do_clr();
    push("R5 mid-record 3", 0, 0, 0, 0);
    send_byte(8'h20, 1'b1);
    send_byte(8'hF3, 1'b0);
    s = 8'h20 + 8'hF3;
    send_byte(8'h03, 1'b1);
    send_byte(gen_csum(s), 1'b0);

    // R6 truncation in body, eod beats a valid byte
    do_clr();
    push("R6 trunc body", 0, 0, 1, 1);
    send_body(4, 2, s);
    eod_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'h03; sor_i = 1'b1;
    @(negedge clk);
    eod_i = 1'b0; byte_vld_i = 1'b0; sor_i = 1'b0;

    // R6 truncation between done-record bytes
    do_clr();
    push("R6 trunc term", 0, 0, 1, 1);
    send_body(3, 9, s);
    send_byte(8'h03, 1'b1);
    eod_i = 1'b1; @(negedge clk); eod_i = 1'b0;
    @(negedge clk);
    chk("R9 abort dropped", abort_o, 0);

    repeat (2) @(negedge clk);
    chk("scoreboard drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #2000000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule